// File: doc/BRIEF.md
# Prescaled-Reset PWM Timer

A single-channel pulse-width generator driven by a slow tick enable (nominally 32 kHz) and programmed through a tiny synchronous register port. An 8-bit counter advances by one on every tick. Rather than comparing against a terminal-count register, the period is chosen by a 2-bit prescaler that names which counter bit clears the counter. The four choices give periods of 128, 64, 32 and 16 ticks, which is 250 Hz, 500 Hz, 1 kHz and 2 kHz at a 32 kHz tick.

The counter bits below the selected clearing bit are compared against a 7-bit duty value. The output is high while that masked count is below the duty value. Writes to the prescaler and to the duty value act at once. They are not shadowed and they do not restart the count, so software must order its writes to avoid glitches. Clearing the enable bit holds the counter at zero and forces the output low.

Top module: `pwmr_timer`

## Requirements
- R1: After reset both registers read zero, the read data is zero and `pwm_out` is low.
- R2: Address 0 is the control register: bit 7 is enable and bits 1:0 are the prescaler. A read returns these bits in the same places and returns zero in bits 6:2. Read data appears one clock after the read strobe and holds until the next read.
- R3: Address 1 is the duty register. It stores write-data bits 6:0 (0 to 127), and bit 7 reads as zero.
- R4: While enabled, the counter advances only on cycles with `tick` high. With prescaler p, the counter clears when its incremented value would set bit 7-p. This gives periods of 128, 64, 32 and 16 ticks for p = 0, 1, 2 and 3.
- R5: `pwm_out` is registered. One clock after any change of count or register, it is high exactly when enabled and (count AND (period-1)) < duty. A duty of 0 gives a constant low output.
- R6: For prescalers 1 to 3, a duty value at or above the period length gives a constant high output. With prescaler 0, even the largest duty (127) leaves the output low for one tick per period.
- R7: While enable is clear, the counter is held at zero, ticks are ignored and `pwm_out` is low. After enable is set, counting starts from zero.
- R8: A change of prescaler does not clear the counter. Counting continues from its present value under the new clearing bit.
- R9: A write to the duty register changes the compare value immediately, part-way through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable, one clock wide, nominally 32 kHz |
| bus_addr | input | 1 | Register select: 0 control, 1 duty |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check on every cycle that the counter is held at zero and the output is low while disabled. They also check that the count moves only on a tick, by one or back to zero, and that a zero duty forces the output low. Two further checks cover the case where a duty at or above the period forces it high, and the case where read-back leaves unused bits zero. The bench scenarios cover what spans many cycles: the high time and period measured for each prescaler, and the one low tick that remains at prescaler 0 with the largest duty. They also show that the count continues across a prescaler change, that a duty write takes effect mid-period, and that counting restarts from zero after re-enable.

// File: rtl/pwmr_pkg.sv
`timescale 1ns/1ps
package pwmr_pkg;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;
  localparam int EN_BIT = 7;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);
endpackage

// File: rtl/pwmr_rst_sync.sv
`timescale 1ns/1ps
module pwmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwmr_regs.sv
`timescale 1ns/1ps
module pwmr_regs #(
  parameter int DATA_W = pwmr_pkg::DATA_W,
  parameter int ADDR_W = pwmr_pkg::ADDR_W,
  parameter int PSC_W  = pwmr_pkg::PSC_W,
  parameter int DUTY_W = pwmr_pkg::CNT_W - 1,
  parameter int EN_BIT = pwmr_pkg::EN_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en,
  output logic [PSC_W-1:0]  psc,
  output logic [DUTY_W-1:0] duty
);
  import pwmr_pkg::*;

  localparam logic [DATA_W-1:0] CTRL_USED =
    (DATA_W'(1) << EN_BIT) | DATA_W'((1 << PSC_W) - 1);

  logic              ctrl_ce, duty_ce, rd_ce;
  logic              en_nxt;
  logic [PSC_W-1:0]  psc_nxt;
  logic [DUTY_W-1:0] duty_nxt;
  logic [DATA_W-1:0] ctrl_img, duty_img, rdata_nxt;

  always_comb begin
    ctrl_ce  = bus_wr && (bus_addr == ADDR_CTRL);
    duty_ce  = bus_wr && (bus_addr == ADDR_DUTY);
    rd_ce    = bus_rd;
    en_nxt   = bus_wdata[EN_BIT];
    psc_nxt  = bus_wdata[PSC_W-1:0];
    duty_nxt = bus_wdata[DUTY_W-1:0];
    ctrl_img = '0;
    ctrl_img[EN_BIT]    = en;
    ctrl_img[PSC_W-1:0] = psc;
    duty_img = DATA_W'(duty);
    rdata_nxt = (bus_addr == ADDR_CTRL) ? ctrl_img : duty_img;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      psc <= '0;
    end else if (ctrl_ce) begin
      en  <= en_nxt;
      psc <= psc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty <= '0;
    else if (duty_ce) duty <= duty_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ce) bus_rdata <= rdata_nxt;
  end

  // R2: unused control bits never appear on the read data
  p_ctrl_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_CTRL) |=> ((bus_rdata & ~CTRL_USED) == '0));

  // R3: duty read-back leaves the top bit clear
  p_duty_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_DUTY) |=> !bus_rdata[DATA_W-1]);

  // R2: read data holds between read strobes
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/pwmr_counter.sv
`timescale 1ns/1ps
module pwmr_counter #(
  parameter int CNT_W = pwmr_pkg::CNT_W,
  parameter int PSC_W = pwmr_pkg::PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] cnt
);
  localparam int NPSC = 1 << PSC_W;

  logic [NPSC-1:0]  psc_dec;
  logic [NPSC-1:0]  wrap_v;
  logic [CNT_W-1:0] cnt_inc, cnt_nxt;
  logic             wrap, cnt_ce;

  assign cnt_inc = cnt + CNT_W'(1);

  for (genvar i = 0; i < NPSC; i++) begin : g_wrap
    assign psc_dec[i] = (psc == PSC_W'(i));
    assign wrap_v[i]  = psc_dec[i] & cnt_inc[CNT_W-1-i];
  end

  always_comb begin
    wrap   = |wrap_v;
    cnt_ce = !en || tick;
    if (!en)       cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_nxt;
  end

  // R7: disabled counter sits at zero
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R4: no tick, no movement
  p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  // R4: a tick steps by one or wraps to zero
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));
endmodule

// File: rtl/pwmr_compare.sv
`timescale 1ns/1ps
module pwmr_compare #(
  parameter int CNT_W  = pwmr_pkg::CNT_W,
  parameter int PSC_W  = pwmr_pkg::PSC_W,
  parameter int DUTY_W = pwmr_pkg::CNT_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PSC_W-1:0]  psc,
  input  logic [DUTY_W-1:0] duty,
  input  logic [CNT_W-1:0]  cnt,
  output logic              pwm_out
);
  localparam int NPSC = 1 << PSC_W;

  logic [CNT_W-1:0] mask_v [NPSC];
  logic [CNT_W-1:0] len_v  [NPSC];
  logic [CNT_W-1:0] mask, period_len, masked, duty_ext;
  logic             below, out_nxt;

  for (genvar i = 0; i < NPSC; i++) begin : g_mask
    assign len_v[i]  = CNT_W'(1) << (CNT_W - 1 - i);
    assign mask_v[i] = len_v[i] - CNT_W'(1);
  end

  always_comb begin
    mask       = mask_v[psc];
    period_len = len_v[psc];
    masked     = cnt & mask;
    duty_ext   = CNT_W'(duty);
    below      = masked < duty_ext;
    out_nxt    = en && below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= out_nxt;
  end

  // R7: disabled output is low
  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  // R5: zero duty never drives high
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm_out);

  // R6: duty covering the whole period drives high
  p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty_ext >= period_len) |=> pwm_out);
endmodule

// File: rtl/pwmr_timer.sv
`timescale 1ns/1ps
module pwmr_timer #(
  parameter int CNT_W  = pwmr_pkg::CNT_W,
  parameter int PSC_W  = pwmr_pkg::PSC_W,
  parameter int DATA_W = pwmr_pkg::DATA_W,
  parameter int ADDR_W = pwmr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int DUTY_W = CNT_W - 1;

  logic              rst_n_i;
  logic              en;
  logic [PSC_W-1:0]  psc;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;

  pwmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_i)
  );

  pwmr_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W),
    .EN_BIT(pwmr_pkg::EN_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en(en), .psc(psc), .duty(duty)
  );

  pwmr_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .en(en), .tick(tick), .psc(psc), .cnt(cnt)
  );

  pwmr_compare #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_i), .en(en), .psc(psc), .duty(duty),
    .cnt(cnt), .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwmr_timer_test.sv
`timescale 1ns/1ps
module pwmr_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [0:0] bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // scoreboard queues: expected high clocks and tag per measurement
  int    exp_q[$];
  string tag_q[$];
  bit    meas_on = 1'b0;

  always #5 clk = ~clk;

  pwmr_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // driver: warm up one period, then measure high clocks over one period
  task automatic measure(input int period, input int duty_v, input string tag);
    int hi;
    ticks(period);
    hi = (duty_v < period ? duty_v : period) * 4;
    exp_q.push_back(hi);
    tag_q.push_back(tag);
    @(negedge clk); meas_on = 1'b1;
    ticks(period);
    meas_on = 1'b0;
    wait (exp_q.size() == 0);
  endtask

  // monitor: counts high samples while measuring, compares on window end
  initial begin
    int  hi_cnt = 0;
    bit  prev = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (meas_on) begin
        hi_cnt += int'(pwm_out);
        prev = 1'b1;
      end else if (prev) begin
        check(hi_cnt, exp_q.pop_front(), tag_q.pop_front());
        hi_cnt = 0;
        prev = 1'b0;
      end
    end
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(int'(pwm_out), 0, "R1 pwm_out after reset");
    bus_read(1'b0, rv); check(int'(rv), 0, "R1 control after reset");
    bus_read(1'b1, rv); check(int'(rv), 0, "R1 duty after reset");

    // R2: control read-back, unused bits zero
    bus_write(1'b0, 8'h02);
    bus_read(1'b0, rv); check(int'(rv), 8'h02, "R2 control readback");
    bus_write(1'b0, 8'h7D);
    bus_read(1'b0, rv); check(int'(rv), 8'h01, "R2 unused control bits");
    // R3: duty 7-bit read-back
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, rv); check(int'(rv), 8'h7F, "R3 duty top bit");
    bus_write(1'b1, 8'h2A);
    bus_read(1'b1, rv); check(int'(rv), 8'h2A, "R3 duty readback");

    // R4 R5: high time over one period for each prescaler
    bus_write(1'b1, 8'd32); bus_write(1'b0, 8'h80);
    measure(128, 32, "R4 presc0 duty32");
    bus_write(1'b1, 8'd10); bus_write(1'b0, 8'h82);
    measure(32, 10, "R4 presc2 duty10");
    bus_write(1'b1, 8'd5); bus_write(1'b0, 8'h83);
    measure(16, 5, "R4 presc3 duty5");
    bus_write(1'b1, 8'd0);
    measure(16, 0, "R5 duty zero low");

    // R6: full and over-range duty
    bus_write(1'b1, 8'd64); bus_write(1'b0, 8'h81);
    measure(64, 64, "R6 presc1 duty64 high");
    bus_write(1'b1, 8'd100); bus_write(1'b0, 8'h83);
    measure(16, 100, "R6 presc3 duty100 high");
    bus_write(1'b1, 8'd127); bus_write(1'b0, 8'h80);
    measure(128, 127, "R6 presc0 duty127 not full");

    // R7: disabled output low while ticks arrive
    bus_write(1'b0, 8'h01);
    measure(64, 0, "R7 disabled low");

    // R8: prescaler change keeps counting
    bus_write(1'b1, 8'd0); bus_write(1'b0, 8'h80);
    ticks(5);                     // count now 5
    bus_write(1'b0, 8'h83); bus_write(1'b1, 8'd5);
    settle();
    check(int'(pwm_out), 0, "R8 count 5 kept after prescaler change");
    ticks(11);                    // 16 clears under bit 4
    check(int'(pwm_out), 1, "R8 wrap under new reset bit");

    // R7: restart from zero after re-enable
    bus_write(1'b1, 8'd1);
    ticks(3);                     // count 3
    bus_write(1'b0, 8'h03);
    settle();
    check(int'(pwm_out), 0, "R7 low when disabled");
    ticks(3);
    bus_write(1'b0, 8'h83);
    settle();
    check(int'(pwm_out), 1, "R7 restart from zero");
    ticks(1);
    check(int'(pwm_out), 0, "R7 count one after first tick");

    // R9: duty write acts mid-period
    bus_write(1'b1, 8'd0); bus_write(1'b0, 8'h81);
    ticks(3);
    settle();
    check(int'(pwm_out), 0, "R9 low before duty write");
    bus_write(1'b1, 8'd64);
    settle();
    check(int'(pwm_out), 1, "R9 immediate duty");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule